// File: doc/BRIEF.md
# Receive Label Filter and Word Queue

This block sits behind a serial word receiver. It takes 32-bit received words and can filter them by label. The label is the low byte of each word. When filtering is on, only words whose label matches one of the labels the CPU has loaded are kept. Kept words go into a receive queue, and the CPU drains that queue one byte at a time over a small register bus.

The CPU sees four addresses: a control register, a status register, a label load port and a queue data port. A reload command makes every loaded label invalid without erasing the storage. After a reload, only labels loaded since then take part in matching. Three queue flags are reported: empty, at-or-above a programmed level, and full. An interrupt line is high while any of the three is high.

Top module: `rx_label_fifo`

## Requirements
- R1: Each write to address 2 stores the data byte as the next valid label, up to LBL_DEPTH labels. Further label writes are ignored until a reload.
- R2: When control bit 0 is 1, a word enters the queue only if its bits [7:0] equal one of the currently valid labels.
- R3: When control bit 0 is 0, every word presented with word_valid enters the queue unchanged.
- R4: Address 0 is the control register. A write sets bit 0 (match enable). If the written bit 7 is 1, all labels become invalid in the same write. A read returns bit 0 and zeros elsewhere, so bit 7 reads 0.
- R5: Reads of address 3 return queued words oldest first, least significant byte first. The word leaves the queue after its fourth byte. A read while the queue is empty returns 0 and changes nothing.
- R6: The flags are fifo_empty (no words), fifo_level (at least FIFO_LEVEL words) and fifo_full (FIFO_DEPTH words). A read of address 1 returns {4'b0, overflow, full, level, empty}.
- R7: irq is high exactly when at least one of fifo_empty, fifo_level and fifo_full is high.
- R8: A read of address 3 raises cpu_wait for the following cycle only. The byte appears on cpu_rdata one cycle later. Reads of addresses 0 to 2 present data on cpu_rdata in the cycle after the read.
- R9: An accepted word that arrives while the queue held FIFO_DEPTH words at the start of that cycle is dropped, and the overflow bit is set. A status read clears the overflow bit, unless a drop happens in that same cycle.
- R10: A push and a word-completing pop in the same cycle both take effect. A label written in the same cycle as a word arrives is not used to match that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Received word present this cycle |
| word_data | input | 32 | Received word, label in bits [7:0] |
| cpu_addr | input | 2 | Register address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| cpu_wait | output | 1 | Queue data byte still being fetched |
| fifo_empty | output | 1 | Queue empty |
| fifo_level | output | 1 | Queue at or above programmed level |
| fifo_full | output | 1 | Queue full |
| irq | output | 1 | Any queue flag high |

## Verification
The case that needs care is a received word arriving in the same cycle as the fourth byte read of a queue word completes a pop. The bench lines this up by raising word_valid in the cycle after it issues the final data-port read. It does this once with the queue full and once with one slot free. When the queue is full, the word must be dropped and the overflow bit set, because fullness is judged on the count at the start of the cycle. With one slot free, the count must stay the same. A label write landing together with a matching word is also provoked, and the word must be rejected. A queue-based reference model is checked against every output on each clock.

// File: rtl/rx_label_fifo.sv
module rx_label_fifo #(
  parameter int LBL_DEPTH  = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int FIFO_LEVEL = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_valid,
  input  logic [31:0] word_data,
  input  logic [1:0]  cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_wait,
  output logic        fifo_empty,
  output logic        fifo_level,
  output logic        fifo_full,
  output logic        irq
);
  localparam int LCW = $clog2(LBL_DEPTH + 1);
  localparam int LIW = (LBL_DEPTH > 1) ? $clog2(LBL_DEPTH) : 1;
  localparam int PW  = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW  = $clog2(FIFO_DEPTH + 1);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_LBL  = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  logic [7:0]           lbl_mem [LBL_DEPTH];
  logic [LCW-1:0]       lbl_cnt;
  logic [LBL_DEPTH-1:0] hit_vec;
  logic                 match_en;
  logic [31:0]          fmem [FIFO_DEPTH];
  logic [PW-1:0]        wptr, rptr;
  logic [CW-1:0]        cnt;
  logic                 rd_pend, ovf;
  logic [1:0]           bsel;
  logic [7:0]           reg_mux;

  genvar g;
  generate
    for (g = 0; g < LBL_DEPTH; g++) begin : g_cmp
      assign hit_vec[g] = (LCW'(g) < lbl_cnt) && (lbl_mem[g] == word_data[7:0]);
    end
  endgenerate

  wire lbl_room = lbl_cnt < LCW'(LBL_DEPTH);
  wire wr_ctrl  = cpu_wr && cpu_addr == A_CTRL;
  wire wr_lbl   = cpu_wr && cpu_addr == A_LBL && lbl_room;
  wire rd_stat  = cpu_rd && cpu_addr == A_STAT;
  wire rd_data  = cpu_rd && cpu_addr == A_DATA;
  wire accept   = word_valid && (!match_en || |hit_vec);
  wire push     = accept && cnt != CW'(FIFO_DEPTH);
  wire drop     = accept && !push;
  wire pop      = rd_pend && cnt != '0 && bsel == 2'd3;

  assign fifo_empty = cnt == '0;
  assign fifo_level = cnt >= CW'(FIFO_LEVEL);
  assign fifo_full  = cnt == CW'(FIFO_DEPTH);
  assign irq        = fifo_empty | fifo_level | fifo_full;
  assign cpu_wait   = rd_pend;

  always_comb begin
    case (cpu_addr)
      A_CTRL:  reg_mux = {7'b0, match_en};
      A_STAT:  reg_mux = {4'b0, ovf, fifo_full, fifo_level, fifo_empty};
      default: reg_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_lbl) lbl_mem[lbl_cnt[LIW-1:0]] <= cpu_wdata;
    if (push)   fmem[wptr] <= word_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbl_cnt  <= '0;
      match_en <= 1'b0;
    end else if (wr_ctrl) begin
      match_en <= cpu_wdata[0];
      if (cpu_wdata[7]) lbl_cnt <= '0;
    end else if (wr_lbl) begin
      lbl_cnt <= lbl_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == PW'(FIFO_DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(FIFO_DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
      ovf <= (ovf && !rd_stat) || drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      bsel      <= 2'd0;
      cpu_rdata <= 8'h00;
    end else begin
      rd_pend <= rd_data;
      if (rd_pend) begin
        if (cnt != '0) begin
          cpu_rdata <= fmem[rptr][{bsel, 3'b000} +: 8];
          bsel      <= bsel + 1'b1;
        end else begin
          cpu_rdata <= 8'h00;
        end
      end
      if (cpu_rd && !rd_data) cpu_rdata <= reg_mux;
    end
  end
endmodule

module rx_label_fifo_chk #(
  parameter int LBL_DEPTH  = 16,
  parameter int FIFO_DEPTH = 16
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             word_valid,
  input logic                             cpu_rd,
  input logic                             cpu_wr,
  input logic [1:0]                       cpu_addr,
  input logic [7:0]                       cpu_wdata,
  input logic                             cpu_wait,
  input logic                             fifo_empty,
  input logic                             fifo_full,
  input logic                             irq,
  input logic                             match_en,
  input logic                             ovf,
  input logic [$clog2(LBL_DEPTH+1)-1:0]   lbl_cnt,
  input logic [$clog2(FIFO_DEPTH+1)-1:0]  cnt
);
  // R1
  lbl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_cnt <= ($clog2(LBL_DEPTH+1))'(LBL_DEPTH));
  // R4
  reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_addr == 2'd0 && cpu_wdata[7] |=> lbl_cnt == '0);
  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));
  // R7
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> irq);
  // R8
  wait_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr == 2'd3 |=> cpu_wait);
  // R8
  wait_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> $past(cpu_rd && cpu_addr == 2'd3));
  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !match_en && fifo_full |=> ovf);
  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && cpu_addr == 2'd1 && !word_valid |=> !ovf);
endmodule

bind rx_label_fifo rx_label_fifo_chk #(.LBL_DEPTH(LBL_DEPTH), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .irq(irq), .match_en(match_en),
  .ovf(ovf), .lbl_cnt(lbl_cnt), .cnt(cnt)
);

// File: tb/rx_label_fifo_bench.sv
module rx_label_fifo_bench;
  localparam int LD = 16, FD = 16, FL = 8;

  logic clk = 0, rst_n = 0, word_valid = 0, cpu_rd = 0, cpu_wr = 0;
  logic [31:0] word_data = '0;
  logic [1:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_wait, fifo_empty, fifo_level, fifo_full, irq;

  rx_label_fifo #(.LBL_DEPTH(LD), .FIFO_DEPTH(FD), .FIFO_LEVEL(FL)) u_rx_label_fifo (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait), .fifo_empty(fifo_empty),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .irq(irq));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit started = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  logic [31:0] q[$];
  logic [7:0]  lbls[$];
  bit          m_en, m_ovf, m_pend, m_hit, m_acc, m_pop;
  logic [1:0]  m_bsel;
  logic [7:0]  m_rdata, m_st;
  int          m_sz;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); lbls.delete();
      m_en = 0; m_ovf = 0; m_pend = 0; m_bsel = 0; m_rdata = 0;
    end else begin
      m_sz = q.size();
      m_hit = 0;
      m_pop = 0;
      foreach (lbls[i]) if (lbls[i] == word_data[7:0]) m_hit = 1;
      m_acc = word_valid && (!m_en || m_hit);
      m_st = {4'b0, m_ovf, m_sz == FD, m_sz >= FL, m_sz == 0};
      if (m_pend) begin
        if (m_sz > 0) begin
          m_rdata = q[0][8*m_bsel +: 8];
          if (m_bsel == 2'd3) m_pop = 1;
          m_bsel = m_bsel + 2'd1;
        end else m_rdata = 0;
      end
      if (cpu_rd && cpu_addr != 2'd3)
        m_rdata = (cpu_addr == 2'd0) ? {7'b0, m_en} : (cpu_addr == 2'd1) ? m_st : 8'h00;
      if (cpu_rd && cpu_addr == 2'd1) m_ovf = 0;
      m_pend = cpu_rd && cpu_addr == 2'd3;
      if (m_pop) void'(q.pop_front());
      if (m_acc) begin
        if (m_sz == FD) m_ovf = 1;
        else q.push_back(word_data);
      end
      if (cpu_wr && cpu_addr == 2'd0) begin
        m_en = cpu_wdata[0];
        if (cpu_wdata[7]) lbls.delete();
      end
      if (cpu_wr && cpu_addr == 2'd2 && lbls.size() < LD) lbls.push_back(cpu_wdata);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R6 empty flag", fifo_empty, q.size() == 0);
      chk("R6 level flag", fifo_level, q.size() >= FL);
      chk("R6 full flag",  fifo_full,  q.size() == FD);
      chk("R7 irq", irq, (q.size() == 0) || (q.size() >= FL) || (q.size() == FD));
      chk("R8 wait", cpu_wait, m_pend);
      chk("R5 rdata", cpu_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic send(input logic [31:0] w);
    word_valid = 1; word_data = w;
    @(negedge clk);
    word_valid = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    cpu_rd = 1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 0;
    d = cpu_rdata;
  endtask

  task automatic rd_byte(output logic [7:0] d, input bit push, input logic [31:0] w);
    cpu_rd = 1; cpu_addr = 2'd3;
    @(negedge clk);
    cpu_rd = 0;
    chk("R8 wait raised", cpu_wait, 1);
    if (push) begin word_valid = 1; word_data = w; end
    @(negedge clk);
    word_valid = 0;
    chk("R8 wait single cycle", cpu_wait, 0);
    d = cpu_rdata;
  endtask

  task automatic read_word(output logic [31:0] w, input bit push, input logic [31:0] pw);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd_byte(b, push && k == 3, pw);
      w[8*k +: 8] = b;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0]  s;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk("R6 reset empty", fifo_empty, 1);
    chk("R6 reset full", fifo_full, 0);
    chk("R7 reset irq", irq, 1);
    chk("R8 reset wait", cpu_wait, 0);
    rst_n = 1;
    @(negedge clk);
    started = 1;

    // R3: no filtering
    send(32'hA1B2C311); send(32'h0000_0077); send(32'hDEADBEEF);
    read_word(w, 0, 0); chk("R3 word 0", w, 32'hA1B2C311);
    read_word(w, 0, 0); chk("R3 word 1", w, 32'h0000_0077);
    read_word(w, 0, 0); chk("R3 word 2", w, 32'hDEADBEEF);
    rd_byte(s, 0, 0); chk("R5 empty read", s, 8'h00);

    // R2: filtering on
    wr(2'd2, 8'h11); wr(2'd2, 8'h22); wr(2'd0, 8'h01);
    rd_reg(2'd0, s); chk("R4 ctrl readback", s, 8'h01);
    send(32'h1000_0011); send(32'h2000_0033); send(32'h3000_0022);
    read_word(w, 0, 0); chk("R2 first match", w, 32'h1000_0011);
    read_word(w, 0, 0); chk("R2 second match", w, 32'h3000_0022);
    rd_reg(2'd1, s); chk("R2 non-match dropped", s, 8'h01);

    // R4: reload
    wr(2'd0, 8'h81);
    rd_reg(2'd0, s); chk("R4 bit7 reads zero", s, 8'h01);
    send(32'h5500_0011);
    rd_reg(2'd1, s); chk("R4 old label invalid", s, 8'h01);
    wr(2'd2, 8'h33); send(32'h4400_0033);
    read_word(w, 0, 0); chk("R4 new label used", w, 32'h4400_0033);

    // R1: label capacity
    wr(2'd0, 8'h81);
    for (int i = 0; i < LD; i++) wr(2'd2, 8'h40 + 8'(i));
    wr(2'd2, 8'h50);
    send(32'h0000_0050);
    rd_reg(2'd1, s); chk("R1 extra label ignored", s, 8'h01);
    send(32'h0000_004F);
    read_word(w, 0, 0); chk("R1 last label kept", w, 32'h0000_004F);

    // R10: label write in same cycle as word
    wr(2'd0, 8'h81);
    cpu_wr = 1; cpu_addr = 2'd2; cpu_wdata = 8'h66; word_valid = 1; word_data = 32'h0000_0066;
    @(negedge clk);
    cpu_wr = 0; word_valid = 0;
    rd_reg(2'd1, s); chk("R10 same-cycle label unused", s, 8'h01);
    send(32'h0000_0066);
    read_word(w, 0, 0); chk("R10 label used later", w, 32'h0000_0066);

    // R6 R7 R9: fill
    wr(2'd0, 8'h00);
    for (int i = 0; i < FL - 1; i++) send(32'h100 + 32'(i));
    chk("R7 irq low mid", irq, 0);
    send(32'h100 + 32'(FL - 1));
    rd_reg(2'd1, s); chk("R6 level status", s, 8'h02);
    for (int i = FL; i < FD; i++) send(32'h100 + 32'(i));
    rd_reg(2'd1, s); chk("R6 full status", s, 8'h06);
    send(32'hBAD0_0000);
    rd_reg(2'd1, s); chk("R9 overflow set", s, 8'h0E);
    rd_reg(2'd1, s); chk("R9 overflow cleared", s, 8'h06);

    // R10 / R9: push coinciding with pop
    read_word(w, 1, 32'hCAFE_0001); chk("R9 pop at full", w, 32'h100);
    rd_reg(2'd1, s); chk("R9 drop on full pop cycle", s, 8'h0A);
    read_word(w, 1, 32'hCAFE_0002); chk("R10 pop with push", w, 32'h101);
    rd_reg(2'd1, s); chk("R10 count kept", s, 8'h02);
    for (int i = 2; i < FD; i++) begin
      read_word(w, 0, 0); chk("R5 order", w, 32'h100 + 32'(i));
    end
    read_word(w, 0, 0); chk("R10 pushed word kept", w, 32'hCAFE_0002);
    rd_reg(2'd1, s); chk("R6 drained", s, 8'h01);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule